// File: doc/BRIEF.md
# Register-Mapped Unsigned Divider

This block is an unsigned integer divider that a processor drives through 32-bit word accesses on a small peripheral window. Software first loads a divisor. It then writes a dividend. The write is the command: one address begins a 32-by-32 division. A second address begins a 64-by-32 division, and that form takes its upper 32 dividend bits from a companion register that software has loaded beforehand.

The engine is a restoring divider. It resolves one quotient bit per clock, so the short form takes 32 cycles and the long form takes 64. While it works, a busy bit can be read back. When it finishes, the remainder replaces the high-word register and the quotient replaces the low-word register. Both values are also copied into two mirror registers. A zero divisor makes the start write inert. A new start while the engine is running abandons the old operation and begins again with the new operands.

Accesses carry a 7-bit word index, which is byte-address bits [8:2]. All offsets in this brief are byte offsets.

Top module: `divu_mmio`

## Requirements
- R1: The register file is decoded from the word index. Divisor at 0x100, short dividend at 0x104, busy at 0x108, high word / remainder at 0x110, low word / quotient at 0x114, remainder mirror at 0x118, quotient mirror at 0x11C. Any other index reads as zero, and writes to it change nothing readable.
- R2: A write to 0x104 with a non-zero divisor starts an unsigned 32/32 divide of the written value. The busy bit is set for exactly 32 cycles after the write edge.
- R3: A write to 0x114 with a non-zero divisor starts a 64/32 divide of {0x110, written value}. The busy bit is set for exactly 64 cycles after the write edge.
- R4: On completion the remainder is written to 0x110 and 0x118, and the quotient is written to 0x114 and 0x11C. Register 0x104 keeps the value software wrote.
- R5: When the divisor is zero, a start write sets no busy bit and leaves 0x110, 0x118 and 0x11C unchanged. The written dividend register still stores the value.
- R6: Bit 0 of 0x108 reads 1 while the engine runs and 0 otherwise, and all other bits read 0. Writes to 0x108 have no effect.
- R7: A start write with a non-zero divisor while busy abandons the running divide. The new divide runs its full length on the new operands.
- R8: When a 64-bit quotient exceeds 32 bits, only its low 32 bits are stored.
- R9: If a software write to a result register lands on the completion edge, the result wins. If a start write lands on the completion edge, the finishing divide is discarded and the new one runs in full.
- R10: After reset every register reads zero and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 7 | Word index (byte-address bits [8:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| div_busy | output | 1 | Engine is running |

## Verification
The completion edge is where the engine and the bus can act in the same cycle. In that cycle the engine's result write-back can coincide with a software write to a result register, or with a new start write. The bench counts cycles from a start so that its next write is captured on exactly the final step edge.

It then checks two outcomes. In the first case the mirror must hold the computed remainder rather than the software value. In the second case the busy bit must stay high for a fresh full run, and the stored results must belong to the second operand set.

// File: rtl/divu_pkg.sv
package divu_pkg;

    localparam int unsigned IDX_W = 7;

    // word indices (byte offset >> 2)
    localparam logic [IDX_W-1:0] IDX_DIVISOR = 7'h40;
    localparam logic [IDX_W-1:0] IDX_DVD32   = 7'h41;
    localparam logic [IDX_W-1:0] IDX_BUSY    = 7'h42;
    localparam logic [IDX_W-1:0] IDX_HIGH    = 7'h44;
    localparam logic [IDX_W-1:0] IDX_LOW     = 7'h45;
    localparam logic [IDX_W-1:0] IDX_REM_M   = 7'h46;
    localparam logic [IDX_W-1:0] IDX_QUO_M   = 7'h47;

    typedef struct packed {
        logic divisor;
        logic dvd32;
        logic high;
        logic low;
        logic rem_m;
        logic quo_m;
    } wr_sel_t;

endpackage

// File: rtl/divu_decode.sv
module divu_decode
    import divu_pkg::*;
(
    input  logic             sel_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    output wr_sel_t          wr_o
);

    logic wr_en;

    always_comb begin
        wr_en      = sel_i & we_i;
        wr_o       = '0;
        wr_o.divisor = wr_en && (idx_i == IDX_DIVISOR);
        wr_o.dvd32   = wr_en && (idx_i == IDX_DVD32);
        wr_o.high    = wr_en && (idx_i == IDX_HIGH);
        wr_o.low     = wr_en && (idx_i == IDX_LOW);
        wr_o.rem_m   = wr_en && (idx_i == IDX_REM_M);
        wr_o.quo_m   = wr_en && (idx_i == IDX_QUO_M);
    end

endmodule

// File: rtl/divu_core.sv
module divu_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  long_i,
    input  logic [2*DATA_W-1:0]   dvd_i,
    input  logic [DATA_W-1:0]     dsr_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [DATA_W-1:0]     quo_o,
    output logic [DATA_W-1:0]     rem_o
);

    localparam int unsigned DVD_W = 2 * DATA_W;
    localparam int unsigned CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DVD_W - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
        logic [DATA_W-1:0] rem;
        logic [DVD_W-1:0]  dvd;
        logic [DATA_W-1:0] dsr;
    } core_t;

    core_t s_d, s_q;

    logic [DATA_W:0]   shifted;
    logic [DATA_W:0]   diff;
    logic              fits;
    logic [DATA_W-1:0] rem_step;
    logic [DVD_W-1:0]  dvd_step;

    // one restoring step: shift in the next dividend bit, try to subtract
    always_comb begin
        shifted  = {s_q.rem, s_q.dvd[DVD_W-1]};
        diff     = shifted - {1'b0, s_q.dsr};
        fits     = ~diff[DATA_W];
        rem_step = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
        dvd_step = {s_q.dvd[DVD_W-2:0], fits};
    end

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.last = long_i ? LAST_LONG : LAST_SHORT;
            s_d.rem  = '0;
            s_d.dvd  = long_i ? dvd_i : {dvd_i[DATA_W-1:0], {DATA_W{1'b0}}};
            s_d.dsr  = dsr_i;
        end else if (s_q.busy) begin
            s_d.rem = rem_step;
            s_d.dvd = dvd_step;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == s_q.last) begin
                s_d.busy = 1'b0;
                done_o   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign quo_o  = dvd_step[DATA_W-1:0];
    assign rem_o  = rem_step;

    // R7: an accepted start always leaves the engine running
    assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R2: the step counter never passes the selected length
    assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt <= s_q.last));

    // R3: completion drops busy on the next cycle
    assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/divu_regs.sv
module divu_regs
    import divu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wr_sel_t              wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 busy_i,
    input  logic                 done_i,
    input  logic [DATA_W-1:0]    quo_i,
    input  logic [DATA_W-1:0]    rem_i,
    output logic                 start_o,
    output logic                 long_o,
    output logic [2*DATA_W-1:0]  dvd_o,
    output logic [DATA_W-1:0]    dsr_o,
    output logic [DATA_W-1:0]    rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] divisor;
        logic [DATA_W-1:0] dvd32;
        logic [DATA_W-1:0] high;
        logic [DATA_W-1:0] low;
        logic [DATA_W-1:0] rem_m;
        logic [DATA_W-1:0] quo_m;
    } regs_t;

    regs_t r_d, r_q;
    logic  start_hit;
    logic  dsr_zero;

    always_comb begin
        start_hit = wr_i.dvd32 | wr_i.low;
        dsr_zero  = (r_q.divisor == '0);
        start_o   = start_hit & ~dsr_zero;
        long_o    = wr_i.low;
        dvd_o     = wr_i.low ? {r_q.high, wdata_i} : {{DATA_W{1'b0}}, wdata_i};
        dsr_o     = r_q.divisor;
    end

    always_comb begin
        r_d = r_q;
        if (wr_i.divisor) r_d.divisor = wdata_i;
        if (wr_i.dvd32)   r_d.dvd32   = wdata_i;
        if (wr_i.high)    r_d.high    = wdata_i;
        if (wr_i.low)     r_d.low     = wdata_i;
        if (wr_i.rem_m)   r_d.rem_m   = wdata_i;
        if (wr_i.quo_m)   r_d.quo_m   = wdata_i;
        // engine results take precedence over a same-cycle software write
        if (done_i) begin
            r_d.high  = rem_i;
            r_d.rem_m = rem_i;
            r_d.low   = quo_i;
            r_d.quo_m = quo_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (idx_i)
            IDX_DIVISOR: rdata_o = r_q.divisor;
            IDX_DVD32:   rdata_o = r_q.dvd32;
            IDX_BUSY:    rdata_o = {{(DATA_W-1){1'b0}}, busy_i};
            IDX_HIGH:    rdata_o = r_q.high;
            IDX_LOW:     rdata_o = r_q.low;
            IDX_REM_M:   rdata_o = r_q.rem_m;
            IDX_QUO_M:   rdata_o = r_q.quo_m;
            default:     rdata_o = '0;
        endcase
    end

    // R5: a start with zero divisor on an idle engine leaves it idle
    assert_zero_divisor_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && dsr_zero && !busy_i) |=> !busy_i);

    // R5: a zero-divisor short start touches no result register
    assert_zero_divisor_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.dvd32 && dsr_zero && !busy_i) |=>
            ($stable(r_q.high) && $stable(r_q.low) && $stable(r_q.rem_m) && $stable(r_q.quo_m)));

    // R4: after completion both copies agree
    assert_mirror_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (r_q.high == r_q.rem_m && r_q.low == r_q.quo_m));

endmodule

// File: rtl/divu_mmio.sv
module divu_mmio
    import divu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              div_busy
);

    wr_sel_t             wr;
    logic                start;
    logic                long_op;
    logic [2*DATA_W-1:0] dvd;
    logic [DATA_W-1:0]   dsr;
    logic                done;
    logic [DATA_W-1:0]   quo;
    logic [DATA_W-1:0]   rem;

    divu_decode u_decode (
        .sel_i (bus_sel),
        .we_i  (bus_we),
        .idx_i (bus_addr),
        .wr_o  (wr)
    );

    divu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .wdata_i (bus_wdata),
        .idx_i   (bus_addr),
        .busy_i  (div_busy),
        .done_i  (done),
        .quo_i   (quo),
        .rem_i   (rem),
        .start_o (start),
        .long_o  (long_op),
        .dvd_o   (dvd),
        .dsr_o   (dsr),
        .rdata_o (bus_rdata)
    );

    divu_core #(.DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .long_i  (long_op),
        .dvd_i   (dvd),
        .dsr_i   (dsr),
        .busy_o  (div_busy),
        .done_o  (done),
        .quo_o   (quo),
        .rem_o   (rem)
    );

endmodule

// File: tb/divu_mmio_test.sv
`timescale 1ns/1ps
module divu_mmio_test;
    import divu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        div_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic rd_stb = 1'b0;

    typedef struct {
        logic [6:0]  idx;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    divu_mmio uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div_busy(div_busy)
    );

    // monitor: compares reads against the scoreboard
    always @(negedge clk) begin
        if (rd_stb) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, got %h", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                if (bus_rdata !== e.data) begin
                    errors++;
                    $display("FAIL %s idx %h: actual %h expected %h", e.tag, e.idx, bus_rdata, e.data);
                end
            end
        end
    end

    task automatic wr(input logic [6:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] idx, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = idx;
        exp_q.push_back('{idx: idx, data: exp, tag: tag});
        rd_stb = 1'b1;
        @(negedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycles the busy output stays high, called just after a write edge
    task automatic busy_len(output int n);
        n = 0;
        while (div_busy && n < 1000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic run_op(input bit long_op, input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] dsr, input string tag,
                          output logic [31:0] q, output logic [31:0] r);
        longint unsigned dvd;
        int n;
        dvd = long_op ? {hi, lo} : {32'h0, lo};
        q = 32'(dvd / {32'h0, dsr});
        r = 32'(dvd % {32'h0, dsr});
        wr(IDX_DIVISOR, dsr);
        if (long_op) begin
            wr(IDX_HIGH, hi);
            wr(IDX_LOW, lo);
        end else begin
            wr(IDX_DVD32, lo);
        end
        busy_len(n);
        chk(n, long_op ? 64 : 32, {tag, " busy length"});
        rd(IDX_HIGH,  r, {tag, " remainder"});
        rd(IDX_REM_M, r, {tag, " remainder mirror"});
        rd(IDX_LOW,   q, {tag, " quotient"});
        rd(IDX_QUO_M, q, {tag, " quotient mirror"});
        if (!long_op) rd(IDX_DVD32, lo, {tag, " R4 short dividend kept"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q, r;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk(div_busy, 0, "R10 busy after reset");
        rd(IDX_DIVISOR, 0, "R10 divisor");
        rd(IDX_DVD32,   0, "R10 short dividend");
        rd(IDX_BUSY,    0, "R10 busy reg");
        rd(IDX_HIGH,    0, "R10 high");
        rd(IDX_LOW,     0, "R10 low");
        rd(IDX_REM_M,   0, "R10 rem mirror");
        rd(IDX_QUO_M,   0, "R10 quo mirror");

        // R1 register storage and unmapped index
        wr(IDX_DIVISOR, 32'h1234_5678);
        rd(IDX_DIVISOR, 32'h1234_5678, "R1 divisor stored");
        wr(7'h43, 32'hFFFF_FFFF);
        rd(7'h43, 0, "R1 unmapped reads zero");
        rd(7'h00, 0, "R1 unmapped low index");

        // R6 busy register ignores writes
        wr(IDX_BUSY, 32'h1);
        chk(div_busy, 0, "R6 busy write ignored");
        rd(IDX_BUSY, 0, "R6 busy reg after write");

        // R2 short divides
        run_op(0, 0, 100, 7, "R2 100/7", q, r);
        run_op(0, 0, 5, 9, "R2 5/9", q, r);
        run_op(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 max/max", q, r);
        // R3 long divides
        run_op(1, 32'h1, 32'h0, 3, "R3 2^32/3", q, r);
        run_op(1, 32'h0, 32'hDEAD_BEEF, 32'h10, "R3 small long", q, r);
        // R8 truncated quotient
        run_op(1, 32'h5, 32'h7, 2, "R8 overflow", q, r);
        chk(q, 32'h8000_0003, "R8 truncated value");

        // R5 zero divisor: results keep q=0x80000003 r=1
        wr(IDX_DIVISOR, 0);
        wr(IDX_DVD32, 55);
        chk(div_busy, 0, "R5 no busy on short zero");
        rd(IDX_DVD32, 55, "R5 short dividend stored");
        rd(IDX_HIGH,  1, "R5 high unchanged");
        rd(IDX_REM_M, 1, "R5 rem mirror unchanged");
        rd(IDX_QUO_M, 32'h8000_0003, "R5 quo mirror unchanged");
        wr(IDX_LOW, 77);
        chk(div_busy, 0, "R5 no busy on long zero");
        rd(IDX_LOW,   77, "R5 low stores written value");
        rd(IDX_HIGH,  1, "R5 high unchanged long");
        rd(IDX_QUO_M, 32'h8000_0003, "R5 quo mirror unchanged long");

        // R6 busy register reads 1 during a run
        wr(IDX_DIVISOR, 10);
        wr(IDX_DVD32, 1000);
        rd(IDX_BUSY, 1, "R6 busy reads one");
        // R7 restart mid-run
        wr(IDX_DVD32, 999);
        busy_len(n);
        chk(n, 32, "R7 restart full length");
        rd(IDX_LOW,  99, "R7 quotient of new operands");
        rd(IDX_HIGH, 9,  "R7 remainder of new operands");
        rd(IDX_BUSY, 0, "R6 busy reads zero after run");

        // R9 software write to a mirror on the completion edge
        wr(IDX_DIVISOR, 7);
        wr(IDX_DVD32, 100);
        repeat (30) @(posedge clk);
        wr(IDX_REM_M, 32'hDEAD_BEEF);
        chk(div_busy, 0, "R9 idle after completion edge");
        rd(IDX_REM_M, 2, "R9 result wins over software write");
        rd(IDX_QUO_M, 14, "R9 quotient mirror");

        // R9 start write on the completion edge
        wr(IDX_DVD32, 50);
        repeat (30) @(posedge clk);
        wr(IDX_DVD32, 200);
        busy_len(n);
        chk(n, 32, "R9 new run after final-edge start");
        rd(IDX_LOW,  28, "R9 quotient of second operands");
        rd(IDX_HIGH, 4,  "R9 remainder of second operands");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule